// File: doc/BRIEF.md
# UART Transmit Scheduler with Bounded Retry

This block sequences the transmit side of a 16550-style serial port. It does not shift bits. It decides when the next character leaves the port, and which byte that is. It takes each byte either from the single holding register or from the head of an external transmit FIFO. It presents the byte to a downstream sink through a valid/ready exchange, and it paces later characters by one computed character period. The holding-empty flag, the transmitter-empty flag and the transmit-empty pending indication are kept here.

The character period is derived from the line settings and from a 16-bit divisor. A byte the sink refuses is kept in the shift register and offered again one character period later. After a bounded number of refusals the byte is discarded. In loopback mode every byte is handed to the receive path instead of the sink, and that hand-off always succeeds.

Top module: `uart_tx_sched`

## Requirements
- R1: After reset, `thre` and `temt` are 1, `tx_empty_pend` is 0, and neither `tx_valid` nor `lb_valid` is asserted until a host write.
- R2: The character period in clock cycles is TICKS_PER_UNIT × divisor × frame. Frame = 1 start bit + (5 + `cfg_lcr[1:0]`) data bits + `cfg_lcr[3]` parity bit + stop bits, where the stop bits are 2 when `cfg_lcr[2]` is 1 and 1 otherwise. Out of reset, divisor 12 and a 10-bit frame give 120 × TICKS_PER_UNIT cycles. Consecutive scheduled attempts are exactly one period apart.
- R3: A configuration write whose divisor is 0 leaves the character period unchanged.
- R4: In the cycle after `thr_wr`, `thre` and `tx_empty_pend` are 0, and in FIFO mode `temt` is also 0. In non-FIFO mode `temt` is left alone. When the scheduler is idle, the write starts an attempt in the next cycle. A write in the same cycle as an attempt takes priority over that attempt setting `thre`.
- R5: In non-FIFO mode an attempt that starts a new byte sends the holding register and sets `thre` right away.
- R6: In FIFO mode an attempt that starts a new byte sends `fifo_head` and pulses `fifo_pop`. It sets `thre` only when `fifo_level` was 1.
- R7: A byte refused by the sink (`tx_ready` = 0 during `tx_valid`) is offered again with the same data one character period later. No new byte is loaded while a retry is in progress. After MAX_RETRY (default 8) retries are also refused, the byte is dropped and the next attempt loads a fresh byte.
- R8: After a completed attempt (accepted or dropped), if `thre` is 0 the next attempt follows one character period later. If `thre` is 1, `temt` and `tx_empty_pend` become 1.
- R9: With `loop_en` = 1 each attempt asserts `lb_valid` with the byte on `lb_data` instead of `tx_valid`, and it is never retried.
- R10: An attempt lasts exactly one cycle, and no two attempts are adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load new line settings and divisor |
| cfg_divisor | input | DIV_W | Baud divisor (0 keeps old period) |
| cfg_lcr | input | 4 | [1:0] data length code, [2] two stop bits, [3] parity enable |
| fifo_en | input | 1 | FIFO mode select |
| loop_en | input | 1 | Route bytes to the receive path |
| thr_wr | input | 1 | Host write of a transmit byte |
| thr_wdata | input | DATA_W | Byte written by the host |
| fifo_level | input | LVL_W | Entries held in the external transmit FIFO |
| fifo_head | input | DATA_W | Byte at the FIFO head |
| fifo_pop | output | 1 | Remove the FIFO head |
| tx_valid | output | 1 | Byte offered to the sink |
| tx_data | output | DATA_W | Byte to the sink |
| tx_ready | input | 1 | Sink accepts the offered byte |
| lb_valid | output | 1 | Byte delivered to the receive path |
| lb_data | output | DATA_W | Looped-back byte |
| thre | output | 1 | Holding path empty |
| temt | output | 1 | Transmitter fully empty |
| tx_empty_pend | output | 1 | Transmit-empty event pending |

## Verification
A host write and a transmit attempt can land in the same cycle. The attempt then loads the old byte and would set `thre`, while the write clears it and supplies a new byte. The bench provokes this in two ways. In non-FIFO mode it issues a second write exactly in the attempt cycle of the first. In FIFO mode it writes back to back, so that the pop of a single-entry FIFO coincides with a push. The bench then requires `thre` and `tx_empty_pend` to stay 0 and the newer byte to go out one character period later. A random FIFO phase with a randomly stalling sink compares every offered byte against the write order, with refused bytes counted toward the drop limit.

// File: rtl/uart_txs_pkg.sv
package uart_txs_pkg;

  typedef enum logic [1:0] {
    TXS_IDLE = 2'd0,
    TXS_ATT  = 2'd1,
    TXS_WAIT = 2'd2
  } txs_state_e;

  // Bits per character: start + data + optional parity + stop.
  function automatic logic [3:0] frame_bits(input logic [3:0] lcr);
    logic [3:0] stop_bits;
    stop_bits = lcr[2] ? 4'd2 : 4'd1;
    return 4'd6 + {2'b00, lcr[1:0]} + {3'b000, lcr[3]} + stop_bits;
  endfunction

endpackage

// File: rtl/uart_txs_period.sv
module uart_txs_period #(
  parameter int unsigned TICKS_PER_UNIT = 1,
  parameter int unsigned DIV_W          = 16,
  parameter int unsigned RST_DIVISOR    = 12,
  parameter int unsigned CT_W           = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic [3:0]       cfg_lcr,
  output logic [CT_W-1:0]  char_ticks
);
  import uart_txs_pkg::*;

  localparam int unsigned RST_TICKS = TICKS_PER_UNIT * RST_DIVISOR * 10;

  logic [CT_W-1:0] ticks_q, ticks_n;
  logic            ticks_en;
  logic [3:0]      frame;

  always_comb begin
    frame    = frame_bits(cfg_lcr);
    ticks_n  = CT_W'(TICKS_PER_UNIT) * CT_W'(cfg_divisor) * CT_W'(frame);
    ticks_en = cfg_wr && (cfg_divisor != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ticks_q <= CT_W'(RST_TICKS);
    else if (ticks_en) ticks_q <= ticks_n;
  end

  assign char_ticks = ticks_q;

endmodule

// File: rtl/uart_txs_src.sv
module uart_txs_src #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_wr,
  input  logic [DATA_W-1:0] thr_wdata,
  input  logic              fifo_en,
  input  logic [DATA_W-1:0] fifo_head,
  input  logic              retry_active,
  input  logic              load,
  output logic [DATA_W-1:0] byte_out
);
  logic [DATA_W-1:0] thr_q;
  logic [DATA_W-1:0] tsr_q;
  logic [DATA_W-1:0] byte_sel;

  always_comb begin
    if (retry_active)  byte_sel = tsr_q;
    else if (fifo_en)  byte_sel = fifo_head;
    else               byte_sel = thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_wr) thr_q <= thr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tsr_q <= '0;
    else if (load) tsr_q <= byte_sel;
  end

  assign byte_out = byte_sel;

endmodule

// File: rtl/uart_txs_ctl.sv
module uart_txs_ctl #(
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned CT_W      = 21,
  parameter int unsigned MAX_RETRY = 8,
  parameter int unsigned RC_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr,
  input  logic             fifo_en,
  input  logic             loop_en,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             tx_ready,
  input  logic [CT_W-1:0]  char_ticks,
  output logic             attempt,
  output logic             load,
  output logic             fifo_pop,
  output logic             retry_active,
  output logic [RC_W-1:0]  retry_cnt,
  output logic             thre,
  output logic             temt,
  output logic             pend
);
  import uart_txs_pkg::*;

  txs_state_e      state_q, state_n;
  logic [CT_W-1:0] cnt_q, cnt_n;
  logic [RC_W-1:0] retry_q, retry_n;
  logic            thre_q, thre_n, temt_q, temt_n, pend_q, pend_n;
  logic            rejected, retry_go, finish, thre_set, last_entry, nonempty;

  always_comb begin
    attempt    = (state_q == TXS_ATT);
    nonempty   = (fifo_level != '0);
    last_entry = (fifo_level == LVL_W'(1)) || !nonempty;
    rejected   = attempt && !loop_en && !tx_ready;
    retry_go   = rejected && (retry_q != RC_W'(MAX_RETRY));
    finish     = attempt && !retry_go;
    load       = attempt && (retry_q == '0);
    fifo_pop   = load && fifo_en && nonempty;
    thre_set   = load && (!fifo_en || last_entry);

    // host write dominates any flag set by a same-cycle attempt
    thre_n = thr_wr ? 1'b0 : (thre_q || thre_set);

    if (thr_wr && fifo_en)    temt_n = 1'b0;
    else if (finish && thre_n) temt_n = 1'b1;
    else                       temt_n = temt_q;

    if (thr_wr)                pend_n = 1'b0;
    else if (finish && thre_n) pend_n = 1'b1;
    else                       pend_n = pend_q;

    if (retry_go)    retry_n = retry_q + RC_W'(1);
    else if (finish) retry_n = '0;
    else             retry_n = retry_q;

    state_n = state_q;
    cnt_n   = cnt_q;
    unique case (state_q)
      TXS_IDLE: if (thr_wr) state_n = TXS_ATT;
      TXS_ATT: begin
        if (retry_go || !thre_n) begin
          state_n = TXS_WAIT;
          cnt_n   = char_ticks - CT_W'(2);
        end else begin
          state_n = TXS_IDLE;
        end
      end
      TXS_WAIT: begin
        if (cnt_q == '0) state_n = TXS_ATT;
        else             cnt_n   = cnt_q - CT_W'(1);
      end
      default: state_n = TXS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXS_IDLE;
      cnt_q   <= '0;
      retry_q <= '0;
      thre_q  <= 1'b1;
      temt_q  <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      retry_q <= retry_n;
      thre_q  <= thre_n;
      temt_q  <= temt_n;
      pend_q  <= pend_n;
    end
  end

  assign retry_active = (retry_q != '0);
  assign retry_cnt    = retry_q;
  assign thre         = thre_q;
  assign temt         = temt_q;
  assign pend         = pend_q;

endmodule

// File: rtl/uart_tx_sched.sv
module uart_tx_sched #(
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned DIV_W          = 16,
  parameter int unsigned FIFO_DEPTH     = 16,
  parameter int unsigned TICKS_PER_UNIT = 1,
  parameter int unsigned MAX_RETRY      = 8,
  parameter int unsigned RST_DIVISOR    = 12,
  localparam int unsigned LVL_W         = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned RC_W          = $clog2(MAX_RETRY + 1),
  localparam int unsigned CT_W          = DIV_W + 4 + $clog2(TICKS_PER_UNIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DIV_W-1:0]  cfg_divisor,
  input  logic [3:0]        cfg_lcr,
  input  logic              fifo_en,
  input  logic              loop_en,
  input  logic              thr_wr,
  input  logic [DATA_W-1:0] thr_wdata,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [DATA_W-1:0] fifo_head,
  output logic              fifo_pop,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              lb_valid,
  output logic [DATA_W-1:0] lb_data,
  output logic              thre,
  output logic              temt,
  output logic              tx_empty_pend
);
  logic [CT_W-1:0]   char_ticks;
  logic              attempt, load, retry_active;
  logic [RC_W-1:0]   retry_cnt;
  logic [DATA_W-1:0] byte_out;

  uart_txs_period #(
    .TICKS_PER_UNIT(TICKS_PER_UNIT), .DIV_W(DIV_W),
    .RST_DIVISOR(RST_DIVISOR), .CT_W(CT_W)
  ) u_period (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .cfg_divisor(cfg_divisor), .cfg_lcr(cfg_lcr), .char_ticks(char_ticks)
  );

  uart_txs_ctl #(
    .LVL_W(LVL_W), .CT_W(CT_W), .MAX_RETRY(MAX_RETRY), .RC_W(RC_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .fifo_en(fifo_en),
    .loop_en(loop_en), .fifo_level(fifo_level), .tx_ready(tx_ready),
    .char_ticks(char_ticks), .attempt(attempt), .load(load),
    .fifo_pop(fifo_pop), .retry_active(retry_active), .retry_cnt(retry_cnt),
    .thre(thre), .temt(temt), .pend(tx_empty_pend)
  );

  uart_txs_src #(.DATA_W(DATA_W)) u_src (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .fifo_en(fifo_en), .fifo_head(fifo_head), .retry_active(retry_active),
    .load(load), .byte_out(byte_out)
  );

  assign tx_valid = attempt && !loop_en;
  assign lb_valid = attempt && loop_en;
  assign tx_data  = byte_out;
  assign lb_data  = byte_out;

endmodule

// File: rtl/uart_tx_sched_chk.sv
module uart_tx_sched_chk #(
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned RC_W      = 4,
  parameter int unsigned MAX_RETRY = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             thr_wr,
  input logic             fifo_en,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_pop,
  input logic             tx_valid,
  input logic             lb_valid,
  input logic             thre,
  input logic             temt,
  input logic             tx_empty_pend,
  input logic [RC_W-1:0]  retry_cnt
);
  // R9
  one_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && lb_valid));

  // R4
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (!thre && !tx_empty_pend));

  // R4
  fifo_write_temt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && fifo_en) |=> !temt);

  // R8
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty_pend) |-> (thre && temt));

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_level != '0));

  // R7
  no_load_in_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (retry_cnt == '0));

  // R7
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= RC_W'(MAX_RETRY));

  // R10
  single_cycle_att_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || lb_valid) |=> !(tx_valid || lb_valid));

endmodule

bind uart_tx_sched uart_tx_sched_chk #(
  .LVL_W(LVL_W), .RC_W(RC_W), .MAX_RETRY(MAX_RETRY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .fifo_en(fifo_en),
  .fifo_level(fifo_level), .fifo_pop(fifo_pop), .tx_valid(tx_valid),
  .lb_valid(lb_valid), .thre(thre), .temt(temt),
  .tx_empty_pend(tx_empty_pend), .retry_cnt(retry_cnt)
);

// File: tb/uart_tx_sched_bench.sv
module uart_tx_sched_bench;
  localparam int MAXR  = 8;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [15:0] cfg_divisor = '0;
  logic [3:0] cfg_lcr = '0;
  logic       fifo_en = 1'b0, loop_en = 1'b0, thr_wr = 1'b0, tx_ready = 1'b1;
  logic [7:0] thr_wdata = '0;
  logic [4:0] fifo_level;
  logic [7:0] fifo_head, tx_data, lb_data;
  logic       fifo_pop, tx_valid, lb_valid, thre, temt, tx_empty_pend;

  uart_tx_sched u_uart_tx_sched (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_divisor(cfg_divisor),
    .cfg_lcr(cfg_lcr), .fifo_en(fifo_en), .loop_en(loop_en), .thr_wr(thr_wr),
    .thr_wdata(thr_wdata), .fifo_level(fifo_level), .fifo_head(fifo_head),
    .fifo_pop(fifo_pop), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .lb_valid(lb_valid), .lb_data(lb_data),
    .thre(thre), .temt(temt), .tx_empty_pend(tx_empty_pend)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int ct_exp = 120;

  // external FIFO model
  logic [7:0] fm [0:31];
  int fm_rd = 0, fm_wr = 0, fm_cnt = 0;
  assign fifo_level = 5'(fm_cnt);
  assign fifo_head  = fm[fm_rd % 32];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      fm_rd <= 0; fm_wr <= 0; fm_cnt <= 0;
    end else begin
      if (thr_wr && fifo_en) begin
        fm[fm_wr % 32] <= thr_wdata;
        fm_wr <= fm_wr + 1;
      end
      if (fifo_pop) fm_rd <= fm_rd + 1;
      fm_cnt <= fm_cnt + ((thr_wr && fifo_en) ? 1 : 0) - (fifo_pop ? 1 : 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int char_time(input int div, input logic [3:0] lcr);
    return div * (1 + 5 + int'(lcr[1:0]) + int'(lcr[3]) + (lcr[2] ? 2 : 1));
  endfunction

  // expected byte order and attempt log
  logic [7:0] exq [0:255];
  int ex_h = 0, ex_t = 0, sb_fails = 0;
  int n_att = 0, last_att = 0;
  int att_cyc [0:1023];
  logic [7:0] att_dat [0:1023];
  bit att_lb [0:1023];

  always @(negedge clk) begin
    if (rst_n && (tx_valid || lb_valid)) begin
      logic [7:0] d;
      bit ok;
      d  = lb_valid ? lb_data : tx_data;
      ok = lb_valid || tx_ready;
      if (n_att < 1024) begin
        att_cyc[n_att] = cyc; att_dat[n_att] = d; att_lb[n_att] = lb_valid;
      end
      check(ex_h != ex_t, "R7", "attempt with nothing written", 1, 0);
      check(d == exq[ex_h % 256], "R7", "attempt byte", int'(d), int'(exq[ex_h % 256]));
      check(lb_valid == loop_en, "R9", "loopback routing", int'(lb_valid), int'(loop_en));
      if (sb_fails > 0)
        check(cyc - last_att == ct_exp, "R7", "retry spacing", cyc - last_att, ct_exp);
      if (ok) begin
        ex_h++; sb_fails = 0;
      end else begin
        sb_fails++;
        if (sb_fails == MAXR + 1) begin ex_h++; sb_fails = 0; end
      end
      last_att = cyc;
      n_att++;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic host_write(input logic [7:0] b);
    thr_wr = 1'b1; thr_wdata = b;
    exq[ex_t % 256] = b; ex_t++;
    @(posedge clk); #1;
    thr_wr = 1'b0;
  endtask

  task automatic configure(input int div, input logic [3:0] lcr);
    cfg_wr = 1'b1; cfg_divisor = 16'(div); cfg_lcr = lcr;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    if (div != 0) ct_exp = char_time(div, lcr);
  endtask

  task automatic wait_att(input int n, input int limit);
    for (int i = 0; i < limit && n_att < n; i++) step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'h1357));
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check(thre == 1, "R1", "thre", int'(thre), 1);
    check(temt == 1, "R1", "temt", int'(temt), 1);
    check(tx_empty_pend == 0, "R1", "pend", int'(tx_empty_pend), 0);
    check(!tx_valid && !lb_valid, "R1", "no attempt", int'(tx_valid), 0);

    // R5 non-FIFO send
    host_write(8'hA5);
    check(thre == 0, "R4", "thre after write", int'(thre), 0);
    check(tx_valid == 1 && tx_data == 8'hA5, "R5", "immediate attempt", int'(tx_data), 8'hA5);
    step();
    check(thre == 1 && temt == 1, "R5", "thre/temt set", int'({thre, temt}), 3);
    check(tx_empty_pend == 1, "R8", "pend raised", int'(tx_empty_pend), 1);
    host_write(8'h3C);
    check(tx_empty_pend == 0, "R4", "pend cleared", int'(tx_empty_pend), 0);
    check(temt == 1, "R4", "temt untouched non-FIFO", int'(temt), 1);
    step();

    // R2 reset period via one refusal
    tx_ready = 1'b0;
    base = n_att;
    host_write(8'h77);
    step();
    tx_ready = 1'b1;
    check(tx_empty_pend == 0, "R8", "no pend during retry", int'(tx_empty_pend), 0);
    wait_att(base + 2, 300);
    check(n_att == base + 2, "R7", "retry attempt seen", n_att, base + 2);
    check(att_cyc[base + 1] - att_cyc[base] == 120, "R2", "reset period",
          att_cyc[base + 1] - att_cyc[base], 120);
    check(att_dat[base + 1] == 8'h77, "R7", "same byte resent", int'(att_dat[base + 1]), 8'h77);
    step();
    check(tx_empty_pend == 1, "R8", "pend after retry ok", int'(tx_empty_pend), 1);

    // R3 zero divisor keeps period
    configure(3, 4'b1100);
    configure(0, 4'b0011);
    tx_ready = 1'b0;
    base = n_att;
    host_write(8'hE1);
    wait_att(base + MAXR + 1, 600);
    step();
    tx_ready = 1'b1;
    check(att_cyc[base + 1] - att_cyc[base] == 27, "R3", "period kept on zero divisor",
          att_cyc[base + 1] - att_cyc[base], 27);
    check(att_cyc[base + 1] - att_cyc[base] == char_time(3, 4'b1100), "R2", "computed period",
          att_cyc[base + 1] - att_cyc[base], char_time(3, 4'b1100));
    // R7 drop after bounded retries
    repeat (60) step();
    check(n_att == base + MAXR + 1, "R7", "attempts before drop", n_att - base, MAXR + 1);
    check(thre && temt && tx_empty_pend, "R8", "flags after drop",
          int'({thre, temt, tx_empty_pend}), 7);
    host_write(8'hE2);
    check(tx_valid && tx_data == 8'hE2, "R7", "fresh byte after drop", int'(tx_data), 8'hE2);
    step();

    // R6 FIFO burst with write colliding with first attempt
    fifo_en = 1'b1;
    base = n_att;
    host_write(8'h11);
    host_write(8'h22);
    host_write(8'h33);
    check(temt == 0, "R4", "temt cleared in FIFO mode", int'(temt), 0);
    wait_att(base + 2, 100);
    step();
    check(thre == 0 && temt == 0, "R6", "thre held while FIFO holds data",
          int'({thre, temt}), 0);
    wait_att(base + 3, 100);
    step();
    check(att_cyc[base + 2] - att_cyc[base + 1] == 27, "R8", "FIFO pacing",
          att_cyc[base + 2] - att_cyc[base + 1], 27);
    check(att_cyc[base + 1] - att_cyc[base] == 27, "R6", "second pop paced",
          att_cyc[base + 1] - att_cyc[base], 27);
    check(thre && temt && tx_empty_pend, "R6", "flags after last pop",
          int'({thre, temt, tx_empty_pend}), 7);
    check(fm_cnt == 0, "R6", "FIFO drained", fm_cnt, 0);
    fifo_en = 1'b0;

    // R9 loopback ignores a refusing sink
    loop_en = 1'b1; tx_ready = 1'b0;
    base = n_att;
    host_write(8'h5A);
    check(lb_valid && !tx_valid && lb_data == 8'h5A, "R9", "loopback byte", int'(lb_data), 8'h5A);
    step();
    check(thre && tx_empty_pend, "R9", "loopback completes", int'({thre, tx_empty_pend}), 3);
    repeat (40) step();
    check(n_att == base + 1, "R9", "no retry in loopback", n_att - base, 1);
    loop_en = 1'b0; tx_ready = 1'b1;

    // R4 collision: second write in the attempt cycle
    base = n_att;
    host_write(8'h61);
    host_write(8'h62);
    check(thre == 0 && tx_empty_pend == 0, "R4", "write beats attempt",
          int'({thre, tx_empty_pend}), 0);
    wait_att(base + 2, 100);
    check(att_cyc[base + 1] - att_cyc[base] == 27, "R8", "colliding byte paced",
          att_cyc[base + 1] - att_cyc[base], 27);
    step();
    check(thre == 1, "R5", "thre after colliding byte", int'(thre), 1);

    // random FIFO phase
    configure(1, 4'b0000);
    fifo_en = 1'b1;
    begin
      int sent = 0;
      for (int i = 0; i < 20000; i++) begin
        if (sent >= 48 && ex_h == ex_t && thre && temt) break;
        tx_ready = ($urandom % 4) != 0;
        if (sent < 48 && fm_cnt < DEPTH - 1 && ($urandom % 3) == 0) begin
          thr_wr = 1'b1; thr_wdata = 8'($urandom);
          exq[ex_t % 256] = thr_wdata; ex_t++; sent++;
        end
        @(posedge clk); #1;
        thr_wr = 1'b0;
      end
    end
    tx_ready = 1'b1;
    repeat (3) step();
    check(ex_h == ex_t, "R7", "every byte sent or dropped", ex_t - ex_h, 0);
    check(thre && temt && tx_empty_pend, "R8", "idle after random run",
          int'({thre, temt, tx_empty_pend}), 7);
    check(fm_cnt == 0, "R6", "FIFO empty after random run", fm_cnt, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule